// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit produces a coarse approximation of 1/sqrt(x) for one IEEE-754 operand at a time. It is meant to seed an iterative refinement elsewhere in a floating-point pipeline, so its answer carries only eight significant fraction bits. A precision-select input picks the format. When `in_dbl` is 1 the operand is a binary64 value on `in_operand[63:0]`. When it is 0 the operand is a binary32 value on `in_operand[31:0]`, and the result appears on `out_result[31:0]` with the upper half zero.

Internally a binary32 operand is widened to binary64, and its subnormals become normal values. The first pipeline stage classifies the operand, normalises subnormals and forms a 9-bit table index. The index combines the parity of the unbiased-shifted exponent with the leading fraction bits. It also forms the result exponent. The second stage reads a 512-entry byte table and packs the result, narrowing back to binary32 when needed. The table is computed by a constant function when the design is elaborated.

Operands enter and results leave through valid/ready handshakes. Results come out in order, and the pipeline stalls cleanly under backpressure.

Top module: `rsqrt_est`

## Requirements
- R1: An infinite operand gives a zero result that keeps the operand's sign bit.
- R2: A zero operand of either sign gives infinity with the operand's sign bit.
- R3: A NaN operand comes back as a NaN with the same sign and payload and with the top fraction bit set, which is bit 51 for binary64 and bit 22 for binary32. A binary32 NaN keeps its 23-bit payload.
- R4: For a finite non-zero operand, let e be the binary64 biased exponent after normalisation. If e is odd, the table index is 128 plus the top 7 fraction bits. If e is even, the index is 256 plus the top 8 fraction bits.
- R5: Table entry i (for i from 128 to 511) is built as follows. Let a = 2i+1 when i < 256, and a = 2·(i OR 1) otherwise. Find the smallest b ≥ 256 for which a·(b+1)² ≥ 2^28. The entry is the low 8 bits of (b+1)>>1. For example, binary64 1.0 gives 0x3FEFF00000000000 and 2.0 gives 0x3FE6900000000000.
- R6: For a finite non-zero operand, the result has three parts. The sign equals the operand's sign. The binary64 exponent field is (3068 − e)/2 in integer division. The table byte sits in fraction bits 51..44, and every lower fraction bit is zero.
- R7: A subnormal operand is handled as follows. Its fraction is shifted left until the leading one reaches the hidden position, and e is lowered by one for each shift. That leading one is then dropped. The index and exponent of R4 and R6 are then formed from the result.
- R8: With `in_dbl` = 0, a binary32 operand is widened exactly, and the result is narrowed exactly with its upper 32 bits zero. For example, 0x41200000 (10.0) gives 0x3EA18000.
- R9: An operand accepted at a clock edge has its result on `out_valid` two edges later when the output is not stalled. Results leave in acceptance order. While `out_valid` is high and `out_ready` is low, `out_result` holds steady.
- R10: During and right after the synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_dbl | input | 1 | 1 selects binary64, 0 selects binary32 in the low half |
| in_operand | input | 64 | Operand bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Estimate, binary32 results in bits 31..0 with the upper half zero |

## Verification
Two situations are the hardest to reach from the ports. The first is the deepest subnormal normalisation, where only the lowest fraction bit is set, in both formats. The second is the moment when both stages hold data while the consumer refuses. The bench drives hand-picked subnormal bit patterns to cover the first. For the second, it streams operands back to back while driving `out_ready` with an irregular pattern of refusals, so `in_ready` drops and the held output must stay unchanged. A sweep over every used table index checks each generated entry against a model that applies the incrementing search rule directly.

// File: rtl/rsqrt_pkg.sv
// Shared constants, types and the elaboration-time estimate table generator
// for the reciprocal square root estimator. Assumes binary64 internal format.
package rsqrt_pkg;

    localparam int WORD_W     = 64;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int EXP_BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SGL_W      = 32;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int SGL_REBIAS = EXP_BIAS - SGL_BIAS;
    localparam int EST_W      = 8;
    localparam int IDX_W      = EST_W + 1;
    localparam int TBL_N      = 1 << IDX_W;
    localparam int EXP_SUM    = 3 * EXP_BIAS - 1;
    localparam int NE_W       = EXP_W + 2;
    localparam int SEARCH_POW = 2 * EST_W + 12;

    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } op_class_e;

    typedef struct packed {
        logic              dbl;
        logic              sign;
        op_class_e         cls;
        logic [FRAC_W-1:0] nan_frac;
        logic [IDX_W-1:0]  idx;
        logic [EXP_W-1:0]  res_exp;
    } s1_payload_t;

    // One table byte: smallest b >= 2^EST_W with a*(b+1)^2 >= 2^SEARCH_POW,
    // found by bisection, then the low byte of (b+1)>>1.
    function automatic logic [EST_W-1:0] est_entry(input int unsigned idx);
        longint unsigned a, lo, hi, mid, lim;
        if (idx < TBL_N / 4) return '0;
        a   = (idx < TBL_N / 2) ? longint'(2 * idx + 1) : longint'((idx | 1) << 1);
        lim = longint'(1) << SEARCH_POW;
        lo  = longint'(1) << EST_W;
        hi  = (longint'(1) << (EST_W + 2)) - 1;
        while (lo < hi) begin
            mid = (lo + hi) >> 1;
            if (a * (mid + 1) * (mid + 1) >= lim) hi = mid;
            else lo = mid + 1;
        end
        return EST_W'((lo + 1) >> 1);
    endfunction

    // Whole table packed into one vector, entry i at bits [i*EST_W +: EST_W].
    function automatic logic [TBL_N*EST_W-1:0] build_table();
        logic [TBL_N*EST_W-1:0] t;
        t = '0;
        for (int i = 0; i < TBL_N; i++) t[i*EST_W +: EST_W] = est_entry(i);
        return t;
    endfunction

endpackage

// File: rtl/rsqrt_lzc.sv
// Leading zero counter. Returns W when the vector is all zero.
// Assumes W >= 1; purely combinational.
module rsqrt_lzc #(
    parameter int W = 52
) (
    input  logic [W-1:0]           vec,
    output logic [$clog2(W+1)-1:0] cnt
);
    localparam int CW = $clog2(W + 1);

    logic found;

    // Scan from the top bit down for the first one.
    always_comb begin
        cnt   = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsqrt_front.sv
// Stage-1 logic: widens binary32 operands to binary64, classifies the
// operand, normalises subnormals, and forms the table index and the result
// exponent. Combinational; assumes binary32 data in operand[31:0].
module rsqrt_front
    import rsqrt_pkg::*;
(
    input  logic              dbl,
    input  logic [WORD_W-1:0] operand,
    output s1_payload_t       pl
);
    localparam int LZ_W = $clog2(FRAC_W + 1);

    logic                     sign;
    logic                     exp_max;
    logic                     exp_min;
    logic [FRAC_W-1:0]        frac;
    logic [NE_W-1:0]          exp_in;
    logic [NE_W-1:0]          sub_base;
    logic [LZ_W-1:0]          lz;
    logic [NE_W-1:0]          exp_n;
    logic [EST_W-1:0]         lead;
    logic [FRAC_W+EST_W-1:0]  ext;
    logic [NE_W-1:0]          diff;
    int                       sh_r;

    rsqrt_lzc #(.W(FRAC_W)) u_lzc (
        .vec (frac),
        .cnt (lz)
    );

    // Unpack the operand and widen binary32 into binary64 fields.
    always_comb begin
        if (dbl) begin
            sign     = operand[WORD_W-1];
            exp_max  = &operand[WORD_W-2 -: EXP_W];
            exp_min  = ~|operand[WORD_W-2 -: EXP_W];
            frac     = operand[FRAC_W-1:0];
            exp_in   = NE_W'(operand[WORD_W-2 -: EXP_W]);
            sub_base = '0;
        end else begin
            sign     = operand[SGL_W-1];
            exp_max  = &operand[SGL_W-2 -: SGL_EXP_W];
            exp_min  = ~|operand[SGL_W-2 -: SGL_EXP_W];
            frac     = {operand[SGL_FRAC_W-1:0], (FRAC_W-SGL_FRAC_W)'(0)};
            exp_in   = NE_W'(operand[SGL_W-2 -: SGL_EXP_W]) + NE_W'(SGL_REBIAS);
            sub_base = NE_W'(SGL_REBIAS);
        end
    end

    // Normalise subnormals: adjust the exponent and take the bits below the leading one.
    always_comb begin
        ext  = {frac, EST_W'(0)};
        sh_r = FRAC_W - 1 - int'(lz);
        if (sh_r < 0) sh_r = 0;
        if (exp_min) begin
            exp_n = sub_base - NE_W'(lz);
            lead  = EST_W'(ext >> sh_r);
        end else begin
            exp_n = exp_in;
            lead  = frac[FRAC_W-1 -: EST_W];
        end
    end

    // Classify the operand and form the index and the halved result exponent.
    always_comb begin
        diff        = NE_W'(EXP_SUM) - exp_n;
        pl.dbl      = dbl;
        pl.sign     = sign;
        pl.nan_frac = frac | {1'b1, (FRAC_W-1)'(0)};
        pl.res_exp  = diff[EXP_W:1];
        pl.idx      = exp_n[0] ? {2'b01, lead[EST_W-1:1]} : {1'b1, lead};
        if (exp_max)                pl.cls = (frac == '0) ? CLS_INF : CLS_NAN;
        else if (exp_min && frac == '0) pl.cls = CLS_ZERO;
        else                        pl.cls = CLS_NUM;
    end
endmodule

// File: rtl/rsqrt_lut.sv
// Estimate table: a constant vector computed at elaboration and read by index.
// Combinational read; entries below a quarter of the depth are never used.
module rsqrt_lut
    import rsqrt_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [EST_W-1:0] est
);
    localparam logic [TBL_N*EST_W-1:0] TBL = build_table();

    // Select one byte of the precomputed table.
    always_comb est = TBL[idx*EST_W +: EST_W];
endmodule

// File: rtl/rsqrt_pack.sv
// Stage-2 packing: builds the binary64 result from the class, exponent and
// table byte, and narrows it to binary32 when the operand was binary32.
// Combinational; narrowing is exact because only the top fraction byte is live.
module rsqrt_pack
    import rsqrt_pkg::*;
(
    input  s1_payload_t       pl,
    input  logic [EST_W-1:0]  est,
    output logic [WORD_W-1:0] res
);
    logic [EXP_W-1:0]     d_exp;
    logic [FRAC_W-1:0]    d_frac;
    logic [SGL_EXP_W-1:0] s_exp;

    // Pick exponent and fraction fields by operand class.
    always_comb begin
        unique case (pl.cls)
            CLS_NUM: begin
                d_exp  = pl.res_exp;
                d_frac = {est, (FRAC_W-EST_W)'(0)};
            end
            CLS_ZERO: begin
                d_exp  = '1;
                d_frac = '0;
            end
            CLS_INF: begin
                d_exp  = '0;
                d_frac = '0;
            end
            default: begin
                d_exp  = '1;
                d_frac = pl.nan_frac;
            end
        endcase
    end

    // Rebias the exponent into binary32 range, keeping the all-ones and zero codes.
    always_comb begin
        if (d_exp == '1)      s_exp = '1;
        else if (d_exp == '0) s_exp = '0;
        else                  s_exp = SGL_EXP_W'(d_exp - EXP_W'(SGL_REBIAS));
    end

    // Assemble the final word in the requested format.
    always_comb begin
        if (pl.dbl) res = {pl.sign, d_exp, d_frac};
        else        res = {(WORD_W-SGL_W)'(0), pl.sign, s_exp, d_frac[FRAC_W-1 -: SGL_FRAC_W]};
    end
endmodule

// File: rtl/rsqrt_est.sv
// Reciprocal square root estimator top: two-stage pipeline with valid/ready
// on both sides. Stage 1 registers the classified operand; stage 2 registers
// the packed result. Synchronous active-low reset clears the valid bits only.
module rsqrt_est
    import rsqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_dbl,
    input  logic [WORD_W-1:0] in_operand,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_result
);
    s1_payload_t       front_pl;
    s1_payload_t       s1_pl;
    logic              s1_valid;
    logic              s1_ready;
    logic              s2_ready;
    logic              s2_dbl;
    logic [EST_W-1:0]  est;
    logic [WORD_W-1:0] packed_res;

    rsqrt_front u_front (
        .dbl     (in_dbl),
        .operand (in_operand),
        .pl      (front_pl)
    );

    rsqrt_lut u_lut (
        .idx (s1_pl.idx),
        .est (est)
    );

    rsqrt_pack u_pack (
        .pl  (s1_pl),
        .est (est),
        .res (packed_res)
    );

    // Stage readiness: a stage advances when the one after it can take data.
    always_comb begin
        s2_ready = !out_valid || out_ready;
        s1_ready = !s1_valid || s2_ready;
        in_ready = s1_ready;
    end

    // Stage-1 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        s1_valid <= 1'b0;
        else if (s1_ready) s1_valid <= in_valid;
    end

    // Stage-1 payload capture on an accepted operand.
    always_ff @(posedge clk) begin
        if (in_valid && s1_ready) s1_pl <= front_pl;
    end

    // Stage-2 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (s2_ready) out_valid <= s1_valid;
    end

    // Stage-2 result capture when stage 1 moves forward.
    always_ff @(posedge clk) begin
        if (s1_valid && s2_ready) begin
            out_result <= packed_res;
            s2_dbl     <= s1_pl.dbl;
        end
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result));

    // R9
    in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |-> out_valid && !out_ready);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s1_pl.cls == CLS_NUM |-> s1_pl.idx[IDX_W-1:IDX_W-2] != 2'b00);

    // R6
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s2_ready |=>
        (($past(s1_pl.dbl) ? out_result[WORD_W-1] : out_result[SGL_W-1]) == $past(s1_pl.sign)));

    // R6
    num_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s2_ready && s1_pl.dbl && s1_pl.cls == CLS_NUM |=>
        out_result[WORD_W-2 -: EXP_W] != '1 && out_result[WORD_W-2 -: EXP_W] != '0);

    // R8
    sgl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !s2_dbl |-> out_result[WORD_W-1:SGL_W] == '0);
endmodule

// File: tb/rsqrt_est_bench.sv
module rsqrt_est_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_dbl = 1'b1;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    int          n_tests = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsqrt_est u_rsqrt_est (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_dbl     (in_dbl),
        .in_operand (in_operand),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural binary64 estimate using the linear search rule.
    function automatic logic [63:0] model_d(input logic [63:0] x);
        logic [63:0] sgn;
        logic [63:0] f;
        logic [63:0] re;
        int e;
        longint unsigned idx, a, b;
        sgn = x & 64'h8000_0000_0000_0000;
        e   = int'(x[62:52]);
        f   = {12'b0, x[51:0]};
        if (e == 2047) return (f == 0) ? sgn : (x | 64'h0008_0000_0000_0000);
        if (e == 0) begin
            if (f == 0) return sgn | 64'h7FF0_0000_0000_0000;
            while (f[51] == 1'b0) begin
                f = f << 1;
                e--;
            end
            f = f << 1;
        end
        if ((e & 1) != 0) idx = ((f >> 45) & 64'hFF) | 64'h80;
        else              idx = ((f >> 44) & 64'hFF) | 64'h100;
        a = (idx < 256) ? (idx << 1) + 1 : ((idx | 1) << 1);
        b = 256;
        while (a * (b + 1) * (b + 1) < (64'd1 << 28)) b++;
        b  = (b + 1) >> 1;
        re = 64'((3068 - e) / 2) & 64'h7FF;
        return sgn | (re << 52) | ((b & 64'hFF) << 44);
    endfunction

    // Behavioural binary32 estimate: widen, estimate, narrow.
    function automatic logic [63:0] model_s(input logic [31:0] x);
        logic        s;
        logic [31:0] f;
        logic [63:0] r;
        int e8, de, se;
        s  = x[31];
        e8 = int'(x[30:23]);
        f  = {9'b0, x[22:0]};
        if (e8 == 255) return (f == 0) ? {32'b0, s, 31'b0} : {32'b0, x | 32'h0040_0000};
        if (e8 == 0 && f == 0) return {32'b0, s, 8'hFF, 23'b0};
        if (e8 != 0) de = e8 + 896;
        else begin
            de = 896;
            while (f[22] == 1'b0) begin
                f = f << 1;
                de--;
            end
            f = (f << 1) & 32'h007F_FFFF;
        end
        r  = model_d({s, 11'(de), f[22:0], 29'b0});
        se = int'(r[62:52]) - 896;
        return {32'b0, s, 8'(se), r[51:29]};
    endfunction

    // One operand through an idle pipe, checking latency and value.
    task automatic one_op(input logic dbl, input logic [63:0] op,
                          input logic [63:0] exp, input string req);
        @(posedge clk); #1;
        in_valid = 1'b1; in_dbl = dbl; in_operand = op; out_ready = 1'b1;
        @(negedge clk);
        chk({req, " R9 in_ready idle"}, 64'(in_ready), 64'd1);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " R9 no early result"}, 64'(out_valid), 64'd0);
        @(negedge clk);
        chk({req, " R9 result after two edges"}, 64'(out_valid), 64'd1);
        chk(req, out_result, exp);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R10 out_valid in reset", 64'(out_valid), 64'd0);
        chk("R10 in_ready in reset", 64'(in_ready), 64'd1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
    endtask

    task automatic test_specials();
        one_op(1'b1, 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, "R1 +inf dbl");
        one_op(1'b1, 64'hFFF0_0000_0000_0000, 64'h8000_0000_0000_0000, "R1 -inf dbl");
        one_op(1'b0, 64'h0000_0000_FF80_0000, 64'h0000_0000_8000_0000, "R1 -inf sgl");
        one_op(1'b1, 64'h0000_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R2 +0 dbl");
        one_op(1'b1, 64'h8000_0000_0000_0000, 64'hFFF0_0000_0000_0000, "R2 -0 dbl");
        one_op(1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_FF80_0000, "R2 -0 sgl");
        one_op(1'b1, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, "R3 sNaN dbl");
        one_op(1'b1, 64'hFFF8_1234_5678_9ABC, 64'hFFF8_1234_5678_9ABC, "R3 qNaN dbl");
        one_op(1'b0, 64'h0000_0000_7F80_0001, 64'h0000_0000_7FC0_0001, "R3 sNaN sgl");
    endtask

    task automatic test_known();
        one_op(1'b1, 64'h3FF0_0000_0000_0000, 64'h3FEF_F000_0000_0000, "R5 R6 1.0");
        one_op(1'b1, 64'h4000_0000_0000_0000, 64'h3FE6_9000_0000_0000, "R5 R6 2.0");
        one_op(1'b1, 64'h4010_0000_0000_0000, 64'h3FDF_F000_0000_0000, "R6 4.0");
        one_op(1'b1, 64'hC000_0000_0000_0000, 64'hBFE6_9000_0000_0000, "R6 -2.0 sign");
        one_op(1'b0, 64'h0000_0000_4120_0000, 64'h0000_0000_3EA1_8000, "R8 10.0 sgl");
    endtask

    task automatic test_parity();
        logic [63:0] v;
        v = 64'h4008_0000_0000_0000; one_op(1'b1, v, model_d(v), "R4 even 3.0");
        v = 64'h3FF8_0000_0000_0000; one_op(1'b1, v, model_d(v), "R4 odd 1.5");
        v = 64'h4020_0000_0000_0000; one_op(1'b1, v, model_d(v), "R4 even 8.0");
        v = 64'h3FE0_0000_0000_0000; one_op(1'b1, v, model_d(v), "R4 even 0.5");
        v = 64'h3FF7_FFFF_FFFF_FFFF; one_op(1'b1, v, model_d(v), "R4 odd high frac");
        one_op(1'b0, 64'h4000_0000, model_s(32'h4000_0000), "R4 R8 sgl 2.0");
        one_op(1'b0, 64'h3F40_0000, model_s(32'h3F40_0000), "R4 R8 sgl 0.75");
    endtask

    task automatic test_subnormal();
        logic [63:0] v;
        v = 64'h0000_0000_0000_0001; one_op(1'b1, v, model_d(v), "R7 dbl min subnormal");
        v = 64'h000F_FFFF_FFFF_FFFF; one_op(1'b1, v, model_d(v), "R7 dbl max subnormal");
        v = 64'h8000_0001_0000_0000; one_op(1'b1, v, model_d(v), "R7 dbl neg subnormal");
        one_op(1'b0, 64'h0000_0001, model_s(32'h0000_0001), "R7 sgl min subnormal");
        one_op(1'b0, 64'h007F_FFFF, model_s(32'h007F_FFFF), "R7 sgl max subnormal");
        one_op(1'b0, 64'h0000_0C00, model_s(32'h0000_0C00), "R7 sgl mid subnormal");
    endtask

    // Every used table entry, odd exponent then even exponent.
    task automatic test_table();
        logic [63:0] v;
        for (int i = 0; i < 128; i++) begin
            v = {1'b0, 11'd1023, 7'(i), 45'h155};
            one_op(1'b1, v, model_d(v), "R5 odd index sweep");
        end
        for (int i = 0; i < 256; i++) begin
            v = {1'b0, 11'd1024, 8'(i), 44'h0AB};
            one_op(1'b1, v, model_d(v), "R5 even index sweep");
        end
    endtask

    // Back-to-back stream with an irregular consumer.
    task automatic test_stream();
        logic [63:0] ops [24];
        logic        dbls [24];
        logic [63:0] exps [24];
        logic [63:0] rng;
        rng = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 24; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            dbls[i] = rng[5];
            ops[i]  = dbls[i] ? rng : {32'b0, rng[31:0]};
            exps[i] = dbls[i] ? model_d(rng) : model_s(rng[31:0]);
        end
        @(posedge clk); #1;
        fork
            begin
                for (int i = 0; i < 24; i++) begin
                    in_valid = 1'b1; in_dbl = dbls[i]; in_operand = ops[i];
                    do @(negedge clk); while (!in_ready);
                    @(posedge clk); #1;
                end
                in_valid = 1'b0;
            end
            begin
                int k = 0;
                int cyc = 0;
                bit was_stall = 1'b0;
                logic [63:0] held = '0;
                while (k < 24) begin
                    @(negedge clk);
                    if (was_stall) begin
                        chk("R9 stalled valid held", 64'(out_valid), 64'd1);
                        chk("R9 stalled result held", out_result, held);
                    end
                    if (out_valid && out_ready) begin
                        chk("R9 R8 stream order", out_result, exps[k]);
                        k++;
                    end
                    was_stall = out_valid && !out_ready;
                    held      = out_result;
                    @(posedge clk); #1;
                    out_ready = ((cyc % 4) != 1) && ((cyc % 7) != 3) && ((cyc % 11) != 5);
                    cyc++;
                end
                out_ready = 1'b1;
            end
        join
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_specials();
        test_known();
        test_parity();
        test_subnormal();
        test_table();
        test_stream();
        repeat (3) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule